// File: doc/BRIEF.md
# Latency-Matched Bypass Delay and Output Selector

This block runs a second copy of each of four 13-bit input channels through a delay line whose length can be programmed from 0 to 127 samples. The length is normally set equal to the latency of the processing core that sits beside the block. An output selector then picks, sample by sample, either the core result or the delayed bypass sample. The choice is made by a pass-control input. When the bypass length matches the core latency, the output stream switches between the two sources with no missing and no repeated sample index.

The selector has a fixed two-clock latency. The pass-control input goes through the same two register stages as the data, so a change of pass-control acts on exactly the sample that was presented alongside it. Length settings above the maximum are clamped. A change of the effective length restarts a fill count, and a valid flag stays low until the delay line again holds a full window of samples at the new length.

Top module: `bypass_align`

## Requirements
- R1: With pass_i high for input sample t and an effective length L of 1 to 127 held since the last change, each channel of out_o shows bypass sample t-L of that channel two clocks after sample t was presented, provided byp_valid_o is high for that sample.
- R2: With effective length 0, a passed sample t shows bypass sample t itself two clocks later, and byp_valid_o is high for every such sample, including the sample on which the length became 0.
- R3: With pass_i low for sample t, out_o shows core sample t two clocks later. pass_i is delayed two clocks along with the data, so a change of pass_i takes effect on the sample presented in the same cycle.
- R4: Channel c occupies bits [13c+12:13c] of byp_i, core_i and out_o. The channels carry independent data and all follow the one pass_i.
- R5: A len_i value above 127 acts as 127. A move between two raw values that both clamp to 127 is not a length change and does not drop byp_valid_o.
- R6: byp_valid_o is aligned with out_o. If the effective length L becomes different at sample n, or n is the first sample after reset, byp_valid_o is low for samples n to n+L-1 and high from sample n+L on while the length is held.
- R7: During reset, and for the first two output cycles after reset is released, out_o is all zeros and byp_valid_o is low.
- R8: When core_i carries the bypass stream delayed by L samples, out_o carries one continuous stream (bypass sample t-L two clocks after sample t), whatever the pattern of pass_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| len_i | input | 8 | Bypass delay length in samples; values above 127 are clamped |
| pass_i | input | 1 | High selects bypass data for this sample, low selects core data |
| byp_i | input | 52 | Four 13-bit bypass input samples |
| core_i | input | 52 | Four 13-bit core result samples |
| out_o | output | 52 | Four 13-bit selected samples, two clocks after their inputs |
| byp_valid_o | output | 1 | High when the bypass sample on out_o's slot comes from a filled delay window |

## Verification
A wrong write or read pointer would put a bypass sample of the wrong age on out_o as soon as a passed sample follows a full fill window. A length sweep from 0 to 127, plus clamped values, shows this within one window of at most 127 samples. A wrong fill counter or change detector shows up on byp_valid_o in the first few samples after a length change, or after a move between raw values that clamp to the same length. A selector or pass-control pipeline that is one stage off shows up on the first sample after any pass_i edge, because the bench toggles pass_i often, including single-sample pulses.

// File: rtl/bypass_align_pkg.sv
// Shared sizing constants for the bypass delay and output selector.
// Assumes the maximum length is at least 1 and the length input is
// at least as wide as the clamped length.
package bypass_align_pkg;
    localparam int unsigned NUM_CH   = 4;
    localparam int unsigned SAMPLE_W = 13;
    localparam int unsigned MAX_LEN  = 127;
    localparam int unsigned LEN_IN_W = 8;
    localparam int unsigned LEN_W    = $clog2(MAX_LEN + 1);
endpackage

// File: rtl/bypass_fill_tracker.sv
// Clamps the raw length input, detects changes of the effective length,
// and reports whether the delay window at that length is filled.
// Assumes LEN_IN_W >= LEN_W. The valid output is combinational and
// refers to the sample presented in the current cycle.
module bypass_fill_tracker #(
    parameter int unsigned LEN_IN_W = bypass_align_pkg::LEN_IN_W,
    parameter int unsigned MAX_LEN  = bypass_align_pkg::MAX_LEN,
    localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LEN_IN_W-1:0] len_raw_i,
    output logic [LEN_W-1:0]    len_eff_o,
    output logic                valid_o
);
    localparam logic [LEN_IN_W-1:0] RAW_LIMIT = LEN_IN_W'(MAX_LEN);
    localparam logic [LEN_W-1:0]    CNT_LIMIT = LEN_W'(MAX_LEN);

    logic [LEN_W-1:0] len_prev;
    logic [LEN_W-1:0] fill_cnt;
    logic [LEN_W-1:0] cnt_cur;
    logic [LEN_W-1:0] cnt_nxt;
    logic             len_chg;

    // Clamp the raw setting to the deepest supported delay.
    always_comb begin
        if (len_raw_i > RAW_LIMIT)
            len_eff_o = CNT_LIMIT;
        else
            len_eff_o = len_raw_i[LEN_W-1:0];
    end

    // Restart the fill count on a change and judge window fill.
    always_comb begin
        len_chg = (len_eff_o != len_prev);
        cnt_cur = len_chg ? '0 : fill_cnt;
        valid_o = (cnt_cur >= len_eff_o);
        cnt_nxt = (cnt_cur == CNT_LIMIT) ? CNT_LIMIT : cnt_cur + 1'b1;
    end

    // Hold the last effective length and the saturating fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_prev <= '0;
            fill_cnt <= '0;
        end else begin
            len_prev <= len_eff_o;
            fill_cnt <= cnt_nxt;
        end
    end

    // A new non-zero length must start with an unfilled window.
    p_invalid_on_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (len_eff_o != $past(len_eff_o)) && (len_eff_o != '0))
        |-> !valid_o);

    // Moving between raw values that both clamp must keep validity.
    p_clamped_no_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(len_raw_i) > RAW_LIMIT) && (len_raw_i > RAW_LIMIT)
         && $past(valid_o)) |-> valid_o);
endmodule

// File: rtl/bypass_delay_line.sv
// One channel of the bypass path: a circular buffer written every cycle
// out of reset, read at the programmed distance behind the write point.
// A length of 0 passes the input straight through. Buffer contents are
// not reset; the fill tracker marks stale reads invalid.
module bypass_delay_line #(
    parameter int unsigned SAMPLE_W = bypass_align_pkg::SAMPLE_W,
    parameter int unsigned MAX_LEN  = bypass_align_pkg::MAX_LEN,
    localparam int unsigned DEPTH   = MAX_LEN + 1,
    localparam int unsigned AW      = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       len_i,
    input  logic [SAMPLE_W-1:0] din_i,
    output logic [SAMPLE_W-1:0] dout_o
);
    localparam logic [AW:0]   DEPTH_X = (AW + 1)'(DEPTH);
    localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);

    logic [SAMPLE_W-1:0] buf_mem [DEPTH];
    logic [AW-1:0]       wr_ptr;
    logic [AW:0]         rd_sum;
    logic [AW:0]         rd_wrap;
    logic [AW-1:0]       rd_addr;

    // Read address sits len_i entries behind the write point, modulo depth.
    always_comb begin
        rd_sum  = {1'b0, wr_ptr} + DEPTH_X - {1'b0, len_i};
        rd_wrap = (rd_sum >= DEPTH_X) ? rd_sum - DEPTH_X : rd_sum;
        rd_addr = rd_wrap[AW-1:0];
    end

    // Zero length bypasses the buffer, otherwise read the aged entry.
    always_comb begin
        if (len_i == '0)
            dout_o = din_i;
        else
            dout_o = buf_mem[rd_addr];
    end

    // Advance the write pointer every active cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_ptr <= '0;
        else if (wr_ptr == LAST)
            wr_ptr <= '0;
        else
            wr_ptr <= wr_ptr + 1'b1;
    end

    // Store the incoming sample at the write point.
    always_ff @(posedge clk) begin
        if (rst_n)
            buf_mem[wr_ptr] <= din_i;
    end

    // Length 1 held across two cycles returns the previous input.
    p_len1_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (len_i == AW'(1)) && ($past(len_i) == AW'(1)))
        |-> (dout_o == $past(din_i)));
endmodule

// File: rtl/bypass_out_select.sv
// Two-stage output selector for all channels. Stage one picks core or
// bypass per the pass control of the same sample; stage two drives the
// port. The bypass-valid flag follows the same two stages.
module bypass_out_select #(
    parameter int unsigned NUM_CH   = bypass_align_pkg::NUM_CH,
    parameter int unsigned SAMPLE_W = bypass_align_pkg::SAMPLE_W,
    localparam int unsigned BUS_W   = NUM_CH * SAMPLE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pass_i,
    input  logic             valid_i,
    input  logic [BUS_W-1:0] core_i,
    input  logic [BUS_W-1:0] byp_i,
    output logic [BUS_W-1:0] out_o,
    output logic             valid_o
);
    logic [BUS_W-1:0] sel_next;
    logic [BUS_W-1:0] sel_q;
    logic             valid_q;

    // Per-channel choice between core and bypass data for this sample.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        always_comb begin
            if (pass_i)
                sel_next[c*SAMPLE_W +: SAMPLE_W] = byp_i[c*SAMPLE_W +: SAMPLE_W];
            else
                sel_next[c*SAMPLE_W +: SAMPLE_W] = core_i[c*SAMPLE_W +: SAMPLE_W];
        end
    end

    // First stage: register the selection and the validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            sel_q   <= sel_next;
            valid_q <= valid_i;
        end
    end

    // Second stage: drive the output port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            out_o   <= sel_q;
            valid_o <= valid_q;
        end
    end

    // Passed samples arrive at the port two clocks later.
    p_pass_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pass_i |=> ##1 (out_o == $past(byp_i, 2)));

    // Core samples arrive at the port two clocks later.
    p_core_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_i |=> ##1 (out_o == $past(core_i, 2)));

    // Validity is aligned with the data it describes.
    p_valid_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ##1 (valid_o == $past(valid_i, 2)));
endmodule

// File: rtl/bypass_align.sv
// Top level: per-channel bypass delay lines sharing one length and fill
// tracker, followed by the two-stage core/bypass output selector.
// Assumes core_i is presented aligned with the input samples of byp_i
// delayed by the core latency, which software programs into len_i.
module bypass_align #(
    parameter int unsigned NUM_CH   = bypass_align_pkg::NUM_CH,
    parameter int unsigned SAMPLE_W = bypass_align_pkg::SAMPLE_W,
    parameter int unsigned MAX_LEN  = bypass_align_pkg::MAX_LEN,
    parameter int unsigned LEN_IN_W = bypass_align_pkg::LEN_IN_W,
    localparam int unsigned BUS_W   = NUM_CH * SAMPLE_W,
    localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LEN_IN_W-1:0] len_i,
    input  logic                pass_i,
    input  logic [BUS_W-1:0]    byp_i,
    input  logic [BUS_W-1:0]    core_i,
    output logic [BUS_W-1:0]    out_o,
    output logic                byp_valid_o
);
    logic [LEN_W-1:0] len_eff;
    logic             fill_ok;
    logic [BUS_W-1:0] byp_dly;

    bypass_fill_tracker #(
        .LEN_IN_W (LEN_IN_W),
        .MAX_LEN  (MAX_LEN)
    ) i_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .len_raw_i (len_i),
        .len_eff_o (len_eff),
        .valid_o   (fill_ok)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_line
        bypass_delay_line #(
            .SAMPLE_W (SAMPLE_W),
            .MAX_LEN  (MAX_LEN)
        ) i_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .len_i  (len_eff),
            .din_i  (byp_i[c*SAMPLE_W +: SAMPLE_W]),
            .dout_o (byp_dly[c*SAMPLE_W +: SAMPLE_W])
        );
    end

    bypass_out_select #(
        .NUM_CH   (NUM_CH),
        .SAMPLE_W (SAMPLE_W)
    ) i_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .pass_i  (pass_i),
        .valid_i (fill_ok),
        .core_i  (core_i),
        .byp_i   (byp_dly),
        .out_o   (out_o),
        .valid_o (byp_valid_o)
    );

    // With no delay a passed input reaches the port after the selector only.
    p_zero_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((len_eff == '0) && pass_i) |=> ##1 (out_o == $past(byp_i, 2)));
endmodule

// File: tb/test_bypass_align.sv
module test_bypass_align;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int SW  = 13;
    localparam int LIM = 127;

    logic            clk;
    logic            rst_n;
    logic [7:0]      len_i;
    logic            pass_i;
    logic [NCH*SW-1:0] byp_i;
    logic [NCH*SW-1:0] core_i;
    logic [NCH*SW-1:0] out_o;
    logic            byp_valid_o;

    bypass_align i_bypass_align (
        .clk         (clk),
        .rst_n       (rst_n),
        .len_i       (len_i),
        .pass_i      (pass_i),
        .byp_i       (byp_i),
        .core_i      (core_i),
        .out_o       (out_o),
        .byp_valid_o (byp_valid_o)
    );

    int checks = 0;
    int fails  = 0;
    int n      = 0;
    int prev_eff = 0;
    int chg_n  = 0;
    int cyc    = 0;

    logic [SW-1:0] hb [256][NCH];
    logic [SW-1:0] hc [256][NCH];
    bit            hp [256];
    int            hl [256];
    int            hraw [256];
    int            hchg [256];
    bit            hr8 [256];

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [SW-1:0] fval(int k, int c);
        return SW'(k * 3 + c * 1111 + 17);
    endfunction

    function automatic logic [SW-1:0] cval(int k, int c);
        return SW'((k * 5 + c * 777) ^ 32'h0AAA);
    endfunction

    task automatic chk(string tag, logic [SW-1:0] act, logic [SW-1:0] exp, int k, int c);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s sample %0d ch %0d: actual %h expected %h", tag, k, c, act, exp);
        end
    endtask

    task automatic chk_bit(string tag, logic act, logic exp, int k);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s sample %0d valid: actual %b expected %b", tag, k, act, exp);
        end
    endtask

    // Compare the port values against the requirement model for sample k.
    task automatic check_sample(int k);
        int  i;
        int  l;
        bit  ev;
        string vt;
        string dt;
        i  = k & 255;
        l  = hl[i];
        ev = (l == 0) || ((k - hchg[i]) >= l);
        vt = (hraw[i] > LIM) ? "R5 R6" : ((l == 0) ? "R2 R6" : "R6");
        chk_bit(vt, byp_valid_o, ev, k);
        for (int c = 0; c < NCH; c++) begin
            if (hp[i]) begin
                if (ev) begin
                    dt = (l == 0) ? "R2 R4" : ((hraw[i] > LIM) ? "R1 R5" : "R1 R4");
                    chk(dt, out_o[c*SW +: SW], hb[(k - l) & 255][c], k, c);
                end
            end else begin
                chk("R3 R4", out_o[c*SW +: SW], hc[i][c], k, c);
            end
            if (hr8[i] && ev)
                chk("R8", out_o[c*SW +: SW], fval(k - l, c), k, c);
        end
    endtask

    // One sample: check the output due now, then present the next inputs.
    task automatic do_sample(int raw, bit p, bit r8);
        int eff;
        int i;
        @(negedge clk);
        if (n >= 2) begin
            check_sample(n - 2);
        end else begin
            chk("R7", out_o[SW-1:0], '0, n, 0);
            chk_bit("R7", byp_valid_o, 1'b0, n);
        end
        eff = (raw > LIM) ? LIM : raw;
        if (n == 0 || eff != prev_eff) chg_n = n;
        prev_eff = eff;
        i = n & 255;
        hl[i] = eff; hraw[i] = raw; hchg[i] = chg_n; hp[i] = p; hr8[i] = r8;
        len_i  = 8'(raw);
        pass_i = p;
        for (int c = 0; c < NCH; c++) begin
            hb[i][c] = fval(n, c);
            hc[i][c] = r8 ? fval(n - eff, c) : cval(n, c);
            byp_i[c*SW +: SW]  = hb[i][c];
            core_i[c*SW +: SW] = hc[i][c];
        end
        n++;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    initial begin
        int lens [14] = '{0, 1, 2, 3, 5, 64, 126, 127, 200, 255, 4, 0, 9, 130};
        rst_n  = 1'b0;
        len_i  = 8'd7;
        pass_i = 1'b1;
        byp_i  = '1;
        core_i = '1;
        // R7: outputs held at zero while reset is asserted.
        for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++) chk("R7", out_o[c*SW +: SW], '0, -1, c);
            chk_bit("R7", byp_valid_o, 1'b0, -1);
        end
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        // Length sweep with mixed pass patterns, including single-sample pulses.
        for (int s = 0; s < 14; s++) begin
            for (int j = 0; j < 300; j++) begin
                bit p;
                p = ((j % 7) == 3) || (((j / (s + 3)) % 2) == 1);
                do_sample(lens[s], p, 1'b0);
            end
        end
        // R8: core stream is the bypass stream aged by the programmed length.
        for (int j = 0; j < 250; j++) do_sample(6, ((j / 9) % 2) == 1, 1'b1);
        for (int j = 0; j < 250; j++) do_sample(40, ((j % 3) == 0), 1'b1);
        for (int j = 0; j < 3; j++) do_sample(40, 1'b0, 1'b0);
        finish_run();
    end
endmodule